// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a memory slave on a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. From these samples it finds start and stop conditions, shifts bytes in and out, and checks the device select word. It then carries out byte and page writes, and current-address, random and sequential reads, against a byte-wide memory port.

The engine pulls the data line low through an open-drain enable output. It never drives the line high. Writes reach the memory as single-cycle strobes, each carrying an address and a data byte. Reads take the byte that the array returns for the current address.

The address is 17 bits wide. Its top bit travels in the device select word, and the other 16 bits travel in two address bytes, high byte first. A persistent address pointer links one transfer to the next. The pointer wraps differently after writes and after reads.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data-line enable is off and no write strobe is issued. The address pointer starts at 0, so a current-address read straight after reset returns the byte at address 0.
- R2: The slave pulls the data line low during the ninth clock of a select word whose bits 7..4 are 1010 and whose bits 3..2 equal `dev_sel` (bit 3 compared with `dev_sel[1]`). In that word, bit 1 is address bit 16 and bit 0 selects the direction (1 = read, 0 = write).
- R3: A select word with a wrong fixed code or a wrong select field gets no acknowledge. No later byte of that transfer gets an acknowledge, no write strobe is issued, and the address pointer is left unchanged.
- R4: In a write, the high address byte (bits 15..8), the low address byte (bits 7..0) and every data byte are each acknowledged. Each data byte produces exactly one write strobe at the current address.
- R5: Successive data bytes of one write go to consecutive addresses. Only the low 8 address bits advance, so the addresses wrap inside the same 256-byte page and earlier bytes of the page are overwritten.
- R6: A read select word returns the byte at the address pointer, MSB first, and then leaves the pointer one past the byte it sent.
- R7: A random read is a write select word plus both address bytes, then a repeated start and a read select word. It returns data starting at the loaded address.
- R8: While the master acknowledges with 0, a read continues with the next address. Past address 0x1FFFF it continues at 0.
- R9: After a write, the pointer holds the address after the last written byte, wrapped inside its page. A write that ends at offset 0xFF of a page leaves the pointer at offset 0x00 of the same page.
- R10: After a read byte that the master does not acknowledge (1), the slave keeps the line released on every later clock until a stop or a start arrives.
- R11: A start or a stop in the middle of a byte abandons that byte without a write strobe. A start always begins reception of a new select word.
- R12: The data-line enable changes only while the bus clock is low, and the slave never takes its own line activity for a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 2 | Strapped select field compared with select word bits 3..2 |
| mem_addr | output | 17 | Address pointer presented to the memory |
| mem_wr_en | output | 1 | Single-cycle write strobe |
| mem_wr_data | output | 8 | Byte to be written |
| mem_rd_data | input | 8 | Byte stored at `mem_addr` |

## Verification
The bench aims at the two wrap rules. A page write is started four bytes below a page end, and a sequential read crosses 0x1FFFF. An engine that wraps writes into the next page, or lets reads wrap inside a page, reads back the wrong bytes or loses the pointer. A read is ended with a NACK and then more clocks are given with no stop. An engine that keeps sending data there, or that treats its own acknowledge as a bus condition, is caught at the line enable. Repeated starts and stops are placed in the middle of a select word and of a data byte. They expose an engine that commits a partial byte or does not re-arm on a start. Select words with the wrong code or wrong strapping must draw no acknowledge and no write strobe.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } twi_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rx_kind_e;

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_sh;
  logic [DEPTH-1:0] sda_sh;
  logic             scl_prv;
  logic             sda_prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_lvl   = scl_sh[DEPTH-2];
  assign sda_lvl   = sda_sh[DEPTH-2];
  assign scl_prv   = scl_sh[DEPTH-1];
  assign sda_prv   = sda_sh[DEPTH-1];

  assign scl_rise  = scl_lvl & ~scl_prv;
  assign scl_fall  = ~scl_lvl & scl_prv;
  // data edges only count as bus conditions while the clock stays high
  assign start_det = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;

endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_rd,
  input  logic              step_wr,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_d = addr_q;
    if (load_en) begin
      addr_d = load_val;
    end else if (step_rd) begin
      addr_d = addr_q + 1'b1;
    end else if (step_wr) begin
      addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
    end
  end

  assign addr_en = load_en | step_rd | step_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/twi_byte_sr.sv
module twi_byte_sr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         cap_bit,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shl_en,
  output logic [W-1:0] data
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_d = sr_q;
    if (load_en) begin
      sr_d = load_val;
    end else if (cap_en) begin
      sr_d = {sr_q[W-2:0], cap_bit};
    end else if (shl_en) begin
      sr_d = {sr_q[W-2:0], 1'b0};
    end
  end

  assign sr_en = load_en | cap_en | shl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign data = sr_q;

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEV_CODE    = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  dev_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [DATA_W-1:0] mem_rd_data
);

  localparam int unsigned CODE_W = DATA_W - SEL_W - 2;
  localparam int unsigned MID_W  = ADDR_W - 1 - DATA_W;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_ni = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst_n    (rst_ni),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  twi_state_e         state_q, state_d;
  rx_kind_e           kind_q, kind_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rw_q, rw_d;
  logic               a16_q, a16_d;
  logic [MID_W-1:0]   ahi_q, ahi_d;
  logic               oe_q, oe_d;
  logic               mack_q, mack_d;

  logic [DATA_W-1:0]  sr_data;
  logic               sr_cap, sr_load, sr_shl;
  logic               ctr_load, step_rd, step_wr;
  logic [ADDR_W-1:0]  ctr_addr;
  logic [ADDR_W-1:0]  ctr_load_val;
  logic               wr_stb;
  logic               go_read;

  logic start_ev, stop_ev, byte_full, dev_hit;

  // a bus condition cannot be produced while this block holds the line low
  assign start_ev  = start_det & ~oe_q;
  assign stop_ev   = stop_det & ~oe_q;
  assign byte_full = (cnt_q == CNT_W'(DATA_W));
  assign dev_hit   = (sr_data[DATA_W-1 -: CODE_W] == CODE_W'(DEV_CODE)) &&
                     (sr_data[2 +: SEL_W] == dev_sel);
  assign sr_cap    = (state_q == ST_RX) && scl_rise && !byte_full;
  assign ctr_load_val = {a16_q, ahi_q, sr_data};

  twi_byte_sr #(.W(DATA_W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cap_en  (sr_cap),
    .cap_bit (sda_lvl),
    .load_en (sr_load),
    .load_val(mem_rd_data),
    .shl_en  (sr_shl),
    .data    (sr_data)
  );

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load_en (ctr_load),
    .load_val(ctr_load_val),
    .step_rd (step_rd),
    .step_wr (step_wr),
    .addr    (ctr_addr)
  );

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    rw_d     = rw_q;
    a16_d    = a16_q;
    ahi_d    = ahi_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    sr_load  = 1'b0;
    sr_shl   = 1'b0;
    ctr_load = 1'b0;
    step_rd  = 1'b0;
    step_wr  = 1'b0;
    wr_stb   = 1'b0;
    go_read  = 1'b0;

    if (start_ev) begin
      state_d = ST_RX;
      kind_d  = RX_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && !byte_full) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            oe_d    = 1'b1;
            state_d = ST_ACK;
            case (kind_q)
              RX_DEV: begin
                if (dev_hit) begin
                  rw_d  = sr_data[0];
                  a16_d = sr_data[1];
                end else begin
                  oe_d    = 1'b0;
                  state_d = ST_IDLE;
                end
              end
              RX_AHI:  ahi_d = sr_data[MID_W-1:0];
              RX_ALO:  ctr_load = 1'b1;
              default: begin
                wr_stb  = 1'b1;
                step_wr = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            oe_d  = 1'b0;
            case (kind_q)
              RX_DEV: begin
                if (rw_q) begin
                  go_read = 1'b1;
                end else begin
                  state_d = ST_RX;
                  kind_d  = RX_AHI;
                end
              end
              RX_AHI: begin
                state_d = ST_RX;
                kind_d  = RX_ALO;
              end
              default: begin
                state_d = ST_RX;
                kind_d  = RX_DATA;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              oe_d    = 1'b0;
              state_d = ST_MACK;
            end else begin
              cnt_d  = cnt_q + 1'b1;
              sr_shl = 1'b1;
              oe_d   = ~sr_data[DATA_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (!mack_q) begin
              go_read = 1'b1;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end

    if (go_read) begin
      state_d = ST_TX;
      sr_load = 1'b1;
      step_rd = 1'b1;
      oe_d    = ~mem_rd_data[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_DEV;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      a16_q   <= 1'b0;
      ahi_q   <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      a16_q   <= a16_d;
      ahi_q   <= ahi_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe      = oe_q;
  assign mem_addr    = ctr_addr;
  assign mem_wr_en   = wr_stb;
  assign mem_wr_data = sr_data;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);

  // R1: the first cycles after reset release leave the line and the strobe quiet
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!sda_oe && !mem_wr_en));

  // R4: every stored byte is followed by an acknowledge
  a_r4_ack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> sda_oe);

  // R4: one strobe per byte
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);

  // R5: write pointer steps within its page
  a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> ((mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])) &&
                   (mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + PAGE_W'(1))));

  // R12: the line enable only moves while the bus clock is low
  a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .mem_wr_en(mem_wr_en),
  .mem_addr (mem_addr)
);

// File: tb/twi_mem_slave_bench.sv
`timescale 1ns/1ps
module twi_mem_slave_bench;

  localparam logic [1:0] SEL   = 2'b10;
  localparam int         AMASK = 'h1FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl;
  logic        sda_m;
  logic        sda_bus;
  logic        sda_oe;
  logic [16:0] mem_addr;
  logic        mem_wr_en;
  logic [7:0]  mem_wr_data;
  logic [7:0]  mem_rd_data;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  twi_mem_slave u_twi_mem_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_oe     (sda_oe),
    .dev_sel    (SEL),
    .mem_addr   (mem_addr),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_data(mem_wr_data),
    .mem_rd_data(mem_rd_data)
  );

  int n_chk = 0, n_fail = 0, wr_cnt = 0, oe_bad = 0, hold_bad = 0, exp_ptr = 0;
  bit hold_watch = 0, done = 0;
  logic oe_prev = 1'b0;
  logic [7:0] arr   [int];
  logic [7:0] ref_m [int];

  function automatic logic [7:0] init_val(int a);
    return 8'(a ^ (a >> 8) ^ (a >> 16) ^ 'h3C);
  endfunction

  function automatic logic [7:0] arr_rd(int a);
    if (arr.exists(a)) return arr[a];
    return init_val(a);
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    if (ref_m.exists(a)) return ref_m[a];
    return init_val(a);
  endfunction

  function automatic logic [7:0] dev_word(logic [1:0] s, logic a16, logic rw);
    return {4'b1010, s, a16, rw};
  endfunction

  // behavioural array and line monitors, all sampled between clock edges
  always @(negedge clk) begin
    if (mem_wr_en === 1'b1) begin
      arr[int'(mem_addr)] = mem_wr_data;
      wr_cnt++;
    end
    mem_rd_data = arr_rd(int'(mem_addr));
    if (rst_n === 1'b1 && sda_oe !== oe_prev && scl === 1'b1) oe_bad++;
    if (hold_watch && sda_oe === 1'b1) hold_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; w(5);
    scl   = 1'b1; w(5);
    sda_m = 1'b0; w(5);
    scl   = 1'b0; w(5);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; w(5);
    scl   = 1'b1; w(5);
    sda_m = 1'b1; w(10);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; w(5);
    scl   = 1'b1; w(5);
    r     = sda_bus; w(5);
    scl   = 1'b0; w(5);
  endtask

  task automatic m_tx(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, ack);
  endtask

  task automatic m_rx(input logic ack_in, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(ack_in, r);
  endtask

  task automatic do_write(int addr, int n, bit with_stop, string tag);
    logic ack;
    logic [7:0] d;
    int page, lo;
    m_start();
    m_tx(dev_word(SEL, addr[16], 1'b0), ack);
    check(ack == 1'b0, "R2 select ack", ack, 0);
    m_tx(8'(addr >> 8), ack);
    check(ack == 1'b0, "R4 high address ack", ack, 0);
    m_tx(8'(addr), ack);
    check(ack == 1'b0, "R4 low address ack", ack, 0);
    page = addr & 'h1FF00;
    lo   = addr & 'hFF;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      m_tx(d, ack);
      check(ack == 1'b0, tag, ack, 0);
      ref_m[page | ((lo + k) & 'hFF)] = d;
    end
    exp_ptr = (n == 0) ? addr : (page | ((lo + n) & 'hFF));
    if (with_stop) m_stop();
  endtask

  task automatic do_read(int n, string tag);
    logic ack;
    logic [7:0] d;
    m_start();
    m_tx(dev_word(SEL, 1'b0, 1'b1), ack);
    check(ack == 1'b0, "R2 read select ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      m_rx(k == n - 1, d);
      check(d == ref_rd(exp_ptr), tag, d, ref_rd(exp_ptr));
      exp_ptr = (exp_ptr + 1) & AMASK;
    end
    m_stop();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d;
    int base, wr_before;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    scl   = 1'b1;
    sda_m = 1'b1;
    w(6);
    rst_n = 1'b1;
    w(6);
    check(sda_oe == 1'b0 && mem_wr_en == 1'b0, "R1 reset outputs", sda_oe, 0);

    // R1 R6: pointer starts at 0
    exp_ptr = 0;
    do_read(1, "R1 read after reset");
    check(exp_ptr == 1, "R6 pointer advanced", exp_ptr, 1);

    // R3: wrong select field, then wrong fixed code
    wr_before = wr_cnt;
    m_start();
    m_tx({4'b1010, ~SEL, 2'b00}, ack);
    check(ack == 1'b1, "R3 wrong select no ack", ack, 1);
    m_tx(8'h12, ack);
    check(ack == 1'b1, "R3 following byte no ack", ack, 1);
    m_stop();
    m_start();
    m_tx({4'b1011, SEL, 2'b00}, ack);
    check(ack == 1'b1, "R3 wrong code no ack", ack, 1);
    m_tx(8'h34, ack);
    m_tx(8'h56, ack);
    m_stop();
    check(wr_cnt == wr_before, "R3 no write strobe", wr_cnt, wr_before);
    do_read(1, "R3 pointer untouched");

    // R4 R7: byte write then random read
    base = 'h1A5C3;
    do_write(base, 1, 1, "R4 data ack");
    check(wr_cnt == wr_before + 1, "R4 one strobe", wr_cnt, wr_before + 1);
    do_write(base, 0, 0, "R7 dummy");
    do_read(1, "R7 random read");

    // R5 R9: page write wrapping within the page
    base = 'h0B7FC;
    do_write(base, 6, 1, "R5 page data ack");
    check(exp_ptr == 'h0B702, "R9 pointer in page", exp_ptr, 'h0B702);
    do_read(1, "R9 current read after page wrap");
    do_write('h0B7FC, 0, 0, "R5 dummy");
    do_read(4, "R5 bytes before page end");
    do_write('h0B700, 0, 0, "R5 dummy");
    do_read(2, "R5 bytes wrapped to page start");
    do_write('h0B800, 0, 0, "R5 dummy");
    do_read(1, "R5 next page untouched");

    // R8: sequential read across top of the address space
    do_write('h1FFFE, 0, 0, "R8 dummy");
    do_read(4, "R8 sequential wrap");
    check(exp_ptr == 2, "R8 pointer after wrap", exp_ptr, 2);

    // R10: NACK then clocks without a stop
    do_write('h00420, 0, 0, "R10 dummy");
    m_start();
    m_tx(dev_word(SEL, 1'b0, 1'b1), ack);
    m_rx(1'b1, d);
    check(d == ref_rd('h420), "R10 byte before nack", d, ref_rd('h420));
    exp_ptr = 'h421;
    hold_watch = 1;
    for (int i = 0; i < 10; i++) m_bit(1'b1, r);
    m_bit(1'b0, r);
    for (int i = 0; i < 8; i++) m_bit(1'b1, r);
    hold_watch = 0;
    check(hold_bad == 0, "R10 line held released", hold_bad, 0);
    m_stop();
    do_read(1, "R10 pointer after nack");

    // R11: start inside a select word, then a full write
    m_start();
    m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r);
    wr_before = wr_cnt;
    do_write('h03311, 1, 1, "R11 write after restart");
    check(wr_cnt == wr_before + 1, "R11 restart write strobe", wr_cnt, wr_before + 1);
    do_write('h03311, 0, 0, "R11 dummy");
    do_read(1, "R11 readback");
    // R11: stop inside a data byte
    wr_before = wr_cnt;
    do_write('h05A5A, 0, 0, "R11 set");
    m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b1, r);
    m_stop();
    check(wr_cnt == wr_before, "R11 partial byte dropped", wr_cnt, wr_before);
    do_read(1, "R11 pointer at loaded address");

    // mixed random traffic
    for (int it = 0; it < 24; it++) begin
      case ($urandom % 3)
        0: do_write(int'($urandom) & AMASK, 1 + int'($urandom % 5), 1, "R4 random write");
        1: begin
          do_write(int'($urandom) & AMASK, 0, 0, "R7 random dummy");
          do_read(1 + int'($urandom % 4), "R7 random read data");
        end
        default: do_read(1 + int'($urandom % 3), "R6 random current read");
      endcase
    end

    // R12: line enable only moved with the clock low, own ack never seen as a condition
    check(oe_bad == 0, "R12 enable moved while clock high", oe_bad, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule